// File: doc/BRIEF.md
# Memory-Mapped Keypad Matrix Scanner

This block connects a 4-row by 8-column key matrix to the read bus of an 8-bit processor. It occupies a 16-byte window in the address map. In a read of that window, the low four address bits act directly as the row drive. A read at one of the four one-hot offsets raises that single row, and on the following cycle the eight column lines appear on the read data. Software can therefore scan the keypad with four reads and needs no row register. Rows are active high. A key at row r, column c connects row line r to column line c.

When the processor is not reading the window, a scanner inside the block walks the rows at a fixed divider rate. It assembles a 32-bit snapshot of the matrix once per frame. A snapshot is accepted as the debounced state only after it has been seen unchanged for a set number of frames in a row. Rollover logic works on that debounced state. It reports one keycode under one-key rollover and raises a flag when more than one key is down. Software reads the result from a status byte at offset 0.

Top module: `kpad_scan_top`

## Requirements
- R1: A read strobe whose address lies in the window (bits 15:4 equal `BASE_HI`, default 0x100) with a one-hot low nibble drives `row_drive` equal to that nibble with `row_oe` high in the strobe cycle. On the next cycle `bus_rdata` equals the column lines of that row, with column c on bit c.
- R2: A window read whose low nibble is neither 0 nor one-hot returns 0x00 on the next cycle and drives no row (`row_oe` low in that cycle).
- R3: A read outside the window returns 0x00 on the next cycle. In cycles without a read strobe, `bus_rdata` is 0x00.
- R4: A read at offset 0 returns the status byte: bit 7 is the valid flag, bit 6 is the multi-key flag, bit 5 is 0, and bits 4:0 are the keycode, equal to row*8+column.
- R5: A status read clears the valid flag after returning it. The keycode is kept.
- R6: A change in the matrix is accepted only after the scanner has seen `DEB` consecutive identical full frames. A press that lasts less than one frame never produces a report.
- R7: When the debounced state holds exactly one key and no key is held from before, that key's code is stored and the valid flag is set.
- R8: While the debounced state holds two or more keys, the multi-key flag reads 1. No keycode is reported for such a group.
- R9: Once a key or a group of keys has been taken, no new key is reported until the debounced state has been empty. This holds when the remaining key is a single one.
- R10: A synchronous reset clears the keycode, the valid flag, the multi-key flag, the scan state and the read data.
- R11: At most one row is driven at any time. No row is driven while `row_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Processor address |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_rdata | output | 8 | Registered read data, valid the cycle after the strobe |
| row_drive | output | 4 | Row lines of the matrix, active high |
| row_oe | output | 1 | Enable of the row tristate buffer |
| col_sense | input | 8 | Column lines of the matrix |

## Verification
The hardest cases to reach are the rollover cases. In these, the debounced state moves from one held key to two keys and then back to a single key without ever becoming empty. The block must report nothing new during that sequence. The bench holds a matrix model driven from `row_drive`. It presses a key, waits longer than the debounce span, adds a second key, and then removes the first. It reads the status byte after each settle and compares the byte with the value it expects from the press history. A press shorter than one frame is applied straight after reset to show that debounce suppresses it. The direct-read path is swept over every low nibble under several matrix patterns.

// File: rtl/kpad_pkg.sv
package kpad_pkg;
  parameter int NROWS  = 4;
  parameter int NCOLS  = 8;
  localparam int KEYS   = NROWS * NCOLS;
  localparam int CODE_W = $clog2(KEYS);
  localparam int ROW_W  = $clog2(NROWS);
  typedef logic [KEYS-1:0] keymap_t;
endpackage

// File: rtl/kpad_bus_dec.sv
module kpad_bus_dec
  import kpad_pkg::*;
#(
  parameter logic [11:0] BASE_HI = 12'h100
) (
  input  logic [15:0]      addr,
  input  logic             rd,
  output logic             win_rd,
  output logic             dir_rd,
  output logic             stat_rd,
  output logic [NROWS-1:0] row_sel
);
  logic [NROWS-1:0] nib;
  logic             nib_onehot;

  assign nib        = addr[NROWS-1:0];
  assign nib_onehot = (nib != '0) && ((nib & (nib - 1'b1)) == '0);
  assign win_rd     = rd && (addr[15:4] == BASE_HI);
  assign dir_rd     = win_rd && nib_onehot;
  assign stat_rd    = win_rd && (addr[3:0] == 4'h0);
  assign row_sel    = dir_rd ? nib : '0;
endmodule

// File: rtl/kpad_scanner.sv
module kpad_scanner
  import kpad_pkg::*;
#(
  parameter int DIV = 1000,
  parameter int DEB = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [NCOLS-1:0] col_sense,
  output logic [NROWS-1:0] scan_drive,
  output logic             scan_oe,
  output keymap_t          deb_map
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CNT_W = $clog2(DEB + 1);

  logic [DIV_W-1:0] div_cnt;
  logic [ROW_W-1:0] ridx;
  logic [CNT_W-1:0] same_cnt, same_nxt;
  keymap_t          snap, frame_now, prev_frame;
  logic             tick, last_row;

  assign tick       = (div_cnt == DIV_W'(DIV - 1)) && !hold;
  assign scan_oe    = tick;
  assign scan_drive = tick ? (NROWS'(1) << ridx) : '0;
  assign last_row   = (ridx == ROW_W'(NROWS - 1));

  always_comb begin
    frame_now = snap;
    frame_now[ridx*NCOLS +: NCOLS] = col_sense;
  end

  always_comb begin
    if (frame_now != prev_frame)
      same_nxt = CNT_W'(1);
    else if (same_cnt >= CNT_W'(DEB))
      same_nxt = CNT_W'(DEB);
    else
      same_nxt = same_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt    <= '0;
      ridx       <= '0;
      snap       <= '0;
      prev_frame <= '0;
      same_cnt   <= '0;
      deb_map    <= '0;
    end else begin
      if (tick)
        div_cnt <= '0;
      else if (div_cnt != DIV_W'(DIV - 1))
        div_cnt <= div_cnt + 1'b1;
      if (tick) begin
        snap <= frame_now;
        ridx <= last_row ? '0 : ridx + 1'b1;
        if (last_row) begin
          prev_frame <= frame_now;
          same_cnt   <= same_nxt;
          if (same_nxt == CNT_W'(DEB))
            deb_map <= frame_now;
        end
      end
    end
  end
endmodule

// File: rtl/kpad_rollover.sv
module kpad_rollover
  import kpad_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  keymap_t           deb_map,
  input  logic              clr,
  output logic              valid,
  output logic              multi,
  output logic              locked,
  output logic [CODE_W-1:0] code
);
  logic              any_key, one_key;
  logic [CODE_W-1:0] enc;

  assign any_key = |deb_map;
  assign one_key = any_key && ((deb_map & (deb_map - 1'b1)) == '0);

  always_comb begin
    enc = '0;
    for (int i = 0; i < KEYS; i++)
      if (deb_map[i]) enc = CODE_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      multi  <= 1'b0;
      locked <= 1'b0;
      code   <= '0;
    end else begin
      multi <= any_key && !one_key;
      if (!locked && any_key) begin
        locked <= 1'b1;
        if (one_key) begin
          code  <= enc;
          valid <= 1'b1;
        end else if (clr) begin
          valid <= 1'b0;
        end
      end else begin
        if (!any_key) locked <= 1'b0;
        if (clr) valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/kpad_scan_top.sv
module kpad_scan_top
  import kpad_pkg::*;
#(
  parameter logic [11:0] BASE_HI = 12'h100,
  parameter int          DIV     = 1000,
  parameter int          DEB     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [15:0]      bus_addr,
  input  logic             bus_rd,
  output logic [7:0]       bus_rdata,
  output logic [NROWS-1:0] row_drive,
  output logic             row_oe,
  input  logic [NCOLS-1:0] col_sense
);
  logic              win_rd, dir_rd, stat_rd;
  logic [NROWS-1:0]  row_sel, scan_drive;
  logic              scan_oe;
  keymap_t           deb_map;
  logic              valid_q, multi_q, locked_q;
  logic [CODE_W-1:0] code_q;

  kpad_bus_dec #(.BASE_HI(BASE_HI)) dec_i (
    .addr(bus_addr), .rd(bus_rd), .win_rd(win_rd), .dir_rd(dir_rd),
    .stat_rd(stat_rd), .row_sel(row_sel)
  );

  kpad_scanner #(.DIV(DIV), .DEB(DEB)) scan_i (
    .clk(clk), .rst(rst), .hold(win_rd), .col_sense(col_sense),
    .scan_drive(scan_drive), .scan_oe(scan_oe), .deb_map(deb_map)
  );

  kpad_rollover roll_i (
    .clk(clk), .rst(rst), .deb_map(deb_map), .clr(stat_rd),
    .valid(valid_q), .multi(multi_q), .locked(locked_q), .code(code_q)
  );

  assign row_drive = dir_rd ? row_sel : scan_drive;
  assign row_oe    = dir_rd | scan_oe;

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= 8'h00;
    else if (dir_rd)
      bus_rdata <= col_sense;
    else if (stat_rd)
      bus_rdata <= {valid_q, multi_q, 1'b0, code_q};
    else
      bus_rdata <= 8'h00;
  end
endmodule

// File: rtl/kpad_scan_chk.sv
module kpad_scan_chk #(
  parameter logic [11:0] BASE_HI = 12'h100
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] bus_addr,
  input logic        bus_rd,
  input logic [7:0]  bus_rdata,
  input logic [3:0]  row_drive,
  input logic        row_oe,
  input logic        valid_q,
  input logic        locked_q
);
  logic       in_win;
  logic [3:0] nib;
  assign in_win = bus_rd && (bus_addr[15:4] == BASE_HI);
  assign nib    = bus_addr[3:0];

  // R11
  row_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_drive));
  // R11
  row_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !row_oe |-> (row_drive == 4'h0));
  // R1
  direct_row_chk: assert property (@(posedge clk) disable iff (rst)
    (in_win && $onehot(nib)) |-> (row_oe && row_drive == nib));
  // R2
  bad_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (in_win && nib != 4'h0 && !$onehot(nib)) |-> !row_oe);
  // R2
  bad_data_chk: assert property (@(posedge clk) disable iff (rst)
    (in_win && nib != 4'h0 && !$onehot(nib)) |=> (bus_rdata == 8'h00));
  // R5
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_win && nib == 4'h0 && locked_q) |=> !valid_q);
  // R9
  report_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $rose(locked_q));
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!valid_q && !locked_q && bus_rdata == 8'h00));
endmodule

bind kpad_scan_top kpad_scan_chk #(.BASE_HI(BASE_HI)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .row_drive(row_drive), .row_oe(row_oe),
  .valid_q(valid_q), .locked_q(locked_q)
);

// File: tb/kpad_scan_top_tb_top.sv
module kpad_scan_top_tb_top;
  localparam int DIV    = 4;
  localparam int DEB    = 3;
  localparam int FRAME  = 4 * DIV;
  localparam int SETTLE = (DEB + 2) * FRAME + 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = 16'h0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [3:0]  row_drive;
  logic        row_oe;
  logic [7:0]  col_sense;
  logic [31:0] km = 32'h0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  kpad_scan_top #(.BASE_HI(12'h100), .DIV(DIV), .DEB(DEB)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .row_drive(row_drive), .row_oe(row_oe),
    .col_sense(col_sense)
  );

  always_comb begin
    col_sense = 8'h00;
    for (int r = 0; r < 4; r++)
      if (row_oe && row_drive[r]) col_sense = col_sense | km[r*8 +: 8];
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d,
                    output logic [3:0] rows, output logic oe);
    @(negedge clk);
    bus_addr = a;
    bus_rd = 1'b1;
    #1;
    rows = row_drive;
    oe = row_oe;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic int row_of(input logic [31:0] m, input logic [3:0] n);
    int v = 0;
    for (int r = 0; r < 4; r++) if (n[r]) v = v | int'(m[r*8 +: 8]);
    return v;
  endfunction

  logic [7:0] d;
  logic [3:0] rws;
  logic       oe;
  int         last_code;
  logic [31:0] pats [4];

  initial begin
    pats[0] = 32'h8001_4002;
    pats[1] = 32'hA5C3_0F10;
    pats[2] = 32'hFFFF_FFFF;
    pats[3] = 32'h0102_0408;
    cyc(3);
    rst = 1'b0;
    cyc(2);
    rd(16'h1000, d, rws, oe);
    check("R10 status after reset", d, 8'h00);

    // R6: short press straight after reset is ignored
    km = 32'h0000_0100;
    cyc(FRAME - 2);
    km = 32'h0;
    cyc(SETTLE);
    rd(16'h1000, d, rws, oe);
    check("R6 short press ignored", d, 8'h00);

    // R1 / R2 / R3 direct read sweep
    foreach (pats[p]) begin
      km = pats[p];
      for (int n = 1; n < 16; n++) begin
        rd(16'h1000 | 16'(n), d, rws, oe);
        if ((n & (n - 1)) == 0) begin
          check("R1 row drive", {27'(0), oe, rws}, {27'(0), 1'b1, 4'(n)});
          check("R1 column data", d, row_of(km, 4'(n)));
        end else begin
          check("R2 no row on bad nibble", oe, 0);
          check("R2 bad nibble data", d, 8'h00);
        end
      end
      rd(16'h2001, d, rws, oe);
      check("R3 outside window", d, 8'h00);
      check("R3 idle data", bus_rdata, 8'h00);
    end
    km = 32'h0;
    cyc(SETTLE);

    // R7 / R4 / R5 single key sweep
    for (int k = 0; k < 32; k++) begin
      km = 32'h1 << k;
      cyc(SETTLE);
      rd(16'h1000, d, rws, oe);
      check("R7 R4 key report", d, 8'h80 | k);
      rd(16'h1000, d, rws, oe);
      check("R5 valid cleared", d, k);
      km = 32'h0;
      cyc(SETTLE);
    end
    last_code = 31;

    // R8: two keys at once
    km = (32'h1 << 3) | (32'h1 << 20);
    cyc(SETTLE);
    rd(16'h1000, d, rws, oe);
    check("R8 multi flag", d, 8'h40 | last_code);
    km = 32'h1 << 20;
    cyc(SETTLE);
    rd(16'h1000, d, rws, oe);
    check("R9 leftover key not reported", d, last_code);
    km = 32'h0;
    cyc(SETTLE);

    // R9: rollover sequence
    km = 32'h1 << 9;
    cyc(SETTLE);
    rd(16'h1000, d, rws, oe);
    check("R9 first key", d, 8'h80 | 9);
    km = (32'h1 << 9) | (32'h1 << 26);
    cyc(SETTLE);
    rd(16'h1000, d, rws, oe);
    check("R9 R8 second key adds multi", d, 8'h40 | 9);
    km = 32'h1 << 26;
    cyc(SETTLE);
    rd(16'h1000, d, rws, oe);
    check("R9 no report while held", d, 9);
    km = 32'h0;
    cyc(SETTLE);
    km = 32'h1 << 26;
    cyc(SETTLE);
    rd(16'h1000, d, rws, oe);
    check("R9 report after release", d, 8'h80 | 26);

    // R10: reset while a report is pending
    km = 32'h0;
    cyc(SETTLE);
    km = 32'h1 << 5;
    cyc(SETTLE);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    km = 32'h0;
    rd(16'h1000, d, rws, oe);
    check("R10 reset clears status", d, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule